// File: doc/BRIEF.md
# Two-Way Inter-Processor Word Mailbox

This block links two processor ports with two independent one-way queues of 32-bit words. Each port owns one queue as its transmit side, and that same queue is the other port's receive side. A port reaches the block through a small register bus with a select, a write strobe, a two-bit register address and a write-data word. Read data is returned in the same cycle as the access.

Each port has three registers: a status word, a transmit-data register that can only be written, and a receive-data register that can only be read. The status word shows both of that port's queues together. It tells whether receive data is waiting and whether the transmit queue has room. It also holds two sticky error flags: one for a write to a full transmit queue and one for a read from an empty receive queue. Any write to the status register clears both flags.

Each port has an interrupt line. The line is high while that port has receive data waiting or has either error flag set.

Top module: `mbox_pair`

## Requirements
- R1: After reset both queues are empty, both status words read 0x00000002 (room available, no data, no flags) and both interrupt lines are low.
- R2: Register addresses are 0 = status (read clears nothing; write clears flags), 1 = transmit data (write pushes), 2 = receive data (read pops). Reads of address 1 or 3, and outputs while a port is not reading, return zero.
- R3: Words pushed by one port are delivered to the other port's receive register in push order, and each queue holds up to 8 words.
- R4: Status bit 0 is 1 exactly when the port's receive queue holds at least one word.
- R5: Status bit 1 is 1 exactly when the port's transmit queue holds fewer than 8 words.
- R6: A transmit write while the queue is full is dropped, leaves the stored words unchanged and sets status bit 2 of the writing port.
- R7: A receive read while the queue is empty returns zero, moves no pointer and sets status bit 3 of the reading port.
- R8: Status bits 2 and 3 stay set until that port writes its status register, which clears both of them on the next cycle.
- R9: A port's interrupt output equals status bit 0 OR bit 2 OR bit 3 of that port.
- R10: The two directions are independent. Both ports may access the block in the same cycle, and one port's errors or clears never change the other port's flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Port A access select |
| a_wr | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 2 | Port A register address |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A read data, same cycle |
| a_irq | output | 1 | Port A interrupt |
| b_sel | input | 1 | Port B access select |
| b_wr | input | 1 | Port B write (1) or read (0) |
| b_addr | input | 2 | Port B register address |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B read data, same cycle |
| b_irq | output | 1 | Port B interrupt |

## Verification
The properties assume that each port makes at most one access per cycle, qualified by its select. This lets a status write and a failed push or pop never fall in the same cycle on the same port. The drop and hold properties also assume that the opposite port is not touching the same queue in that cycle, so each one is guarded on the other port's access. The stimulus drives only well-formed single accesses. It covers simultaneous traffic on both ports, including a push into a full queue while the other side pops it, which the model treats as a dropped write.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_TXD  = 2'd1,
    REG_RXD  = 2'd2,
    REG_RSVD = 2'd3
  } mbox_reg_e;

  localparam int ST_DATA = 0;
  localparam int ST_ROOM = 1;
  localparam int ST_OVF  = 2;
  localparam int ST_UDF  = 3;
  localparam int ST_W    = 4;

  function automatic logic [ST_W-1:0] pack_status(
    input logic has_data, input logic room,
    input logic ovf, input logic udf);
    logic [ST_W-1:0] s;
    s = '0;
    s[ST_DATA] = has_data;
    s[ST_ROOM] = room;
    s[ST_OVF]  = ovf;
    s[ST_UDF]  = udf;
    return s;
  endfunction

  function automatic logic irq_of(input logic has_data,
                                  input logic ovf, input logic udf);
    return has_data | ovf | udf;
  endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;

endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic          tx_full,
  input  logic          rx_empty,
  input  logic [DW-1:0] rx_head,
  output logic          push_try,
  output logic          pop_try,
  output logic          tx_push,
  output logic          rx_pop,
  output logic          clr_evt,
  output logic          ovf_q,
  output logic          udf_q,
  output logic [DW-1:0] rdata,
  output logic          irq
);

  mbox_reg_e     reg_sel;
  logic          rd_acc;
  logic          ovf_evt, udf_evt;
  logic [ST_W-1:0] status;

  assign reg_sel  = mbox_reg_e'(addr);
  assign rd_acc   = sel & ~wr;
  assign push_try = sel & wr & (reg_sel == REG_TXD);
  assign pop_try  = rd_acc & (reg_sel == REG_RXD);
  assign clr_evt  = sel & wr & (reg_sel == REG_STAT);
  assign tx_push  = push_try & ~tx_full;
  assign rx_pop   = pop_try & ~rx_empty;
  assign ovf_evt  = push_try & tx_full;
  assign udf_evt  = pop_try & rx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else if (clr_evt) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (ovf_evt) ovf_q <= 1'b1;
      if (udf_evt) udf_q <= 1'b1;
    end
  end

  assign status = pack_status(~rx_empty, ~tx_full, ovf_q, udf_q);

  always_comb begin
    rdata = '0;
    if (rd_acc) begin
      case (reg_sel)
        REG_STAT: rdata = DW'(status);
        REG_RXD:  rdata = rx_empty ? '0 : rx_head;
        default:  rdata = '0;
      endcase
    end
  end

  assign irq = irq_of(~rx_empty, ovf_q, udf_q);

endmodule

// File: rtl/mbox_pair.sv
module mbox_pair #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_sel,
  input  logic          a_wr,
  input  logic [1:0]    a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_sel,
  input  logic          b_wr,
  input  logic [1:0]    b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);

  localparam int NP = 2;

  // Index i is port i; queue i is port i's transmit queue.
  logic [NP-1:0]          p_sel, p_wr;
  logic [NP-1:0][1:0]     p_addr;
  logic [NP-1:0][DW-1:0]  p_wdata, p_rdata;
  logic [NP-1:0]          p_irq;

  logic [NP-1:0]          push_try, pop_try, tx_push, rx_pop, clr_evt;
  logic [NP-1:0]          ovf_q, udf_q;
  logic [NP-1:0]          q_full, q_empty;
  logic [NP-1:0][DW-1:0]  q_head;
  logic [NP-1:0][CW-1:0]  q_cnt;

  assign p_sel   = {b_sel, a_sel};
  assign p_wr    = {b_wr, a_wr};
  assign p_addr  = {b_addr, a_addr};
  assign p_wdata = {b_wdata, a_wdata};
  assign a_rdata = p_rdata[0];
  assign b_rdata = p_rdata[1];
  assign a_irq   = p_irq[0];
  assign b_irq   = p_irq[1];

  for (genvar i = 0; i < NP; i++) begin : g_side
    mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push[i]),
      .pop   (rx_pop[NP-1-i]),
      .din   (p_wdata[i]),
      .head  (q_head[i]),
      .full  (q_full[i]),
      .empty (q_empty[i]),
      .count (q_cnt[i])
    );

    mbox_port #(.DW(DW)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (p_sel[i]),
      .wr       (p_wr[i]),
      .addr     (p_addr[i]),
      .tx_full  (q_full[i]),
      .rx_empty (q_empty[NP-1-i]),
      .rx_head  (q_head[NP-1-i]),
      .push_try (push_try[i]),
      .pop_try  (pop_try[i]),
      .tx_push  (tx_push[i]),
      .rx_pop   (rx_pop[i]),
      .clr_evt  (clr_evt[i]),
      .ovf_q    (ovf_q[i]),
      .udf_q    (udf_q[i]),
      .rdata    (p_rdata[i]),
      .irq      (p_irq[i])
    );
  end

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          push_try,
  input logic [1:0]          pop_try,
  input logic [1:0]          clr_evt,
  input logic [1:0]          q_full,
  input logic [1:0]          q_empty,
  input logic [1:0]          ovf_q,
  input logic [1:0]          udf_q,
  input logic [1:0]          p_irq,
  input logic [1:0][CW-1:0]  q_cnt
);

  for (genvar i = 0; i < 2; i++) begin : g_chk
    // R5: occupancy never exceeds the depth
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt[i] <= CW'(DEPTH));

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_try[i] && q_full[i]) |=> ovf_q[i]);

    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_try[i] && q_full[i] && !pop_try[1-i]) |=> $stable(q_cnt[i]));

    p_udf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_try[i] && q_empty[1-i]) |=> udf_q[i]);

    p_empty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_try[i] && q_empty[1-i] && !push_try[1-i]) |=> q_empty[1-i]);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[i] && !clr_evt[i]) |=> ovf_q[i]);

    p_udf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (udf_q[i] && !clr_evt[i]) |=> udf_q[i]);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_evt[i] |=> (!ovf_q[i] && !udf_q[i]));

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      p_irq[i] |-> (!q_empty[1-i] || ovf_q[i] || udf_q[i]));

    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_empty[1-i] || ovf_q[i] || udf_q[i]) |-> p_irq[i]);
  end

endmodule

bind mbox_pair mbox_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .push_try (push_try),
  .pop_try  (pop_try),
  .clr_evt  (clr_evt),
  .q_full   (q_full),
  .q_empty  (q_empty),
  .ovf_q    (ovf_q),
  .udf_q    (udf_q),
  .p_irq    (p_irq),
  .q_cnt    (q_cnt)
);

// File: tb/sim_mbox_pair.sv
module sim_mbox_pair;

  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
  logic [1:0] a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq, b_irq;

  always #4 clk = ~clk;

  mbox_pair u0 (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R1";

  // Reference model: qa carries A->B words, qb carries B->A words.
  logic [31:0] qa[$];
  logic [31:0] qb[$];
  bit ovf[2];
  bit udf[2];

  function automatic logic [31:0] exp_rdata(int p, bit s, bit w, logic [1:0] ad);
    int txn, rxn;
    logic [31:0] v;
    txn = (p == 0) ? qa.size() : qb.size();
    rxn = (p == 0) ? qb.size() : qa.size();
    v = 32'h0;
    if (s && !w) begin
      if (ad == 2'd0)
        v = {28'h0, udf[p], ovf[p], (txn < DEPTH), (rxn > 0)};
      else if (ad == 2'd2 && rxn > 0)
        v = (p == 0) ? qb[0] : qa[0];
    end
    return v;
  endfunction

  function automatic bit exp_irq(int p);
    int rxn;
    rxn = (p == 0) ? qb.size() : qa.size();
    return (rxn > 0) || ovf[p] || udf[p];
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit as, input bit aw, input logic [1:0] aa, input logic [31:0] ad,
                     input bit bs, input bit bw, input logic [1:0] ba, input logic [31:0] bd);
    int sa, sb;
    bit a_push, a_pop, b_push, b_pop;
    @(negedge clk);
    a_sel = as; a_wr = aw; a_addr = aa; a_wdata = ad;
    b_sel = bs; b_wr = bw; b_addr = ba; b_wdata = bd;
    #1;
    check("A rdata", a_rdata, exp_rdata(0, as, aw, aa));
    check("B rdata", b_rdata, exp_rdata(1, bs, bw, ba));
    check("A irq", {31'h0, a_irq}, {31'h0, exp_irq(0)});
    check("B irq", {31'h0, b_irq}, {31'h0, exp_irq(1)});
    @(posedge clk);
    sa = qa.size(); sb = qb.size();
    a_push = as && aw && aa == 2'd1;
    a_pop  = as && !aw && aa == 2'd2;
    b_push = bs && bw && ba == 2'd1;
    b_pop  = bs && !bw && ba == 2'd2;
    if (as && aw && aa == 2'd0) begin ovf[0] = 0; udf[0] = 0; end
    if (bs && bw && ba == 2'd0) begin ovf[1] = 0; udf[1] = 0; end
    if (a_push && sa >= DEPTH) ovf[0] = 1;
    if (b_push && sb >= DEPTH) ovf[1] = 1;
    if (a_pop && sb == 0) udf[0] = 1;
    if (b_pop && sa == 0) udf[1] = 1;
    if (a_pop && sb > 0) void'(qb.pop_front());
    if (b_pop && sa > 0) void'(qa.pop_front());
    if (a_push && sa < DEPTH) qa.push_back(ad);
    if (b_push && sb < DEPTH) qb.push_back(bd);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic run_all();
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";  // reset state of both status words
    cyc(1, 0, 0, 0, 1, 0, 0, 0);

    cur_req = "R3";  // ordered delivery A->B, R4 status while waiting
    cyc(1, 1, 1, 32'hA000_0001, 0, 0, 0, 0);
    cyc(1, 1, 1, 32'hA000_0002, 0, 0, 0, 0);
    cyc(1, 1, 1, 32'hA000_0003, 1, 0, 0, 0);
    cur_req = "R4";
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    cur_req = "R3";
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 1, 0, 2, 0);
    cur_req = "R2";  // reserved and write-only addresses read zero
    cyc(1, 0, 1, 0, 1, 0, 3, 0);

    cur_req = "R5";  // fill B->A to depth, check room bit falls
    for (int k = 0; k < DEPTH; k++) cyc(0, 0, 0, 0, 1, 1, 1, 32'hB0 + k);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    cur_req = "R6";  // push into full queue is dropped
    cyc(0, 0, 0, 0, 1, 1, 1, 32'hDEAD_BEEF);
    cyc(1, 0, 0, 0, 1, 0, 0, 0);
    for (int k = 0; k < DEPTH; k++) cyc(1, 0, 2, 0, 0, 0, 0, 0);

    cur_req = "R7";  // read from empty queue returns zero
    cyc(1, 0, 2, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 1, 0, 0, 0);

    cur_req = "R10"; // A clears its flags, B flags untouched
    cyc(1, 1, 0, 32'hFFFF_FFFF, 1, 0, 0, 0);
    cur_req = "R8";  // flags held until the status write, then cleared
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, 0, 0);
    cyc(1, 0, 0, 0, 1, 0, 0, 0);

    cur_req = "R9";  // interrupt from underflow only, then from data
    cyc(0, 0, 0, 0, 1, 0, 2, 0);
    idle();
    cyc(0, 0, 0, 0, 1, 1, 0, 0);
    cyc(1, 1, 1, 32'h1234_5678, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 2, 0);

    cur_req = "R10"; // mixed traffic on both ports every cycle
    lf = 32'h1ACE_B00C;
    for (int k = 0; k < 600; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      cyc(lf[0], lf[1], lf[3:2], lf ^ 32'h5A5A_0000,
          lf[4], lf[5] & lf[8], lf[7:6], lf ^ 32'h0000_A5A5);
    end
    cur_req = "R3";
    for (int k = 0; k < DEPTH + 1; k++) cyc(1, 0, 2, 0, 1, 0, 2, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule